// File: doc/BRIEF.md
# Multiplexed Correlated-Sampling Pulse-Height Extractor

The block receives four ADC lanes at once. Each lane cycles through eight analog channels in a fixed rotation, so the block sees 32 channels in total. It splits the lanes into one sample stream per channel. For every new sample it checks one candidate leading edge on that channel. That edge lies far enough back that the samples on both sides of it have already arrived. The check covers PAIRS sample pairs placed symmetrically around the edge. Pair k takes the difference between the sample k after the edge and the sample k+1 before it. Each pair difference is multiplied by its own signed coefficient, and the products are summed to give the pulse height.

There is no trigger or gate input. The block processes every sample and finds hits on its own. The innermost pair difference is compared with a threshold that software writes, together with the coefficients, through a plain register write port. One shared multiply-accumulate engine serves all channels in turn. Each channel's recent samples are kept in a store indexed by channel number.

A hit produces a record holding the channel number, the weighted height and a 32-bit timestamp. The timestamp counts sample ticks (62.5 ns bins at 16 Msps), and an external time reference can load it. Both the sample input and the record output use valid/ready handshakes:
- A transfer happens on a clock edge where valid and ready are both high.
- `in_ready` stays low while the shared engine is still working on the previous tick.
- Records wait in a 16-entry FIFO. While `out_valid` is high and `out_ready` is low, the record at the output holds still.
- A record that finds the FIFO full is dropped, and a sticky flag records the loss.

Top module: `mcs_pulse_extractor`

## Requirements
- R1: A tick accepted in time slot s delivers the sample of lane L to channel L*8+s. The slot is 0 after reset and advances by one, modulo 8, on each accepted tick. Within one tick, lanes are processed in order 0 to 3.
- R2: After reset `in_ready` is 1. A tick is accepted on a clock edge where `in_valid` and `in_ready` are both 1, and `in_ready` is 0 in the cycle after an accepted tick.
- R3: For each new sample x[t] of a channel, the candidate edge is e = t-(PAIRS-1). A hit is declared when the signed difference x[e]-x[e-1] is strictly greater than the signed threshold, and the same channel's previous candidate edge was not over the threshold.
- R4: The record height is the sum over k = 0..PAIRS-1 of coef[k]*(x[e+k]-x[e-k-1]). Samples are unsigned and differences are signed. Each channel's history reads as zero after reset.
- R5: A write with `cfg_addr` = k < PAIRS sets coef[k] (signed 16-bit). A write with `cfg_addr` = PAIRS sets the threshold. Writes to any other address are ignored. After reset the coefficients are 0 and the threshold is 32767, so no hit can occur.
- R6: The tick counter is 0 after reset and adds 1 for each accepted tick. While `ts_set` is high it loads `ts_set_value`, which becomes the stamp of the next accepted tick. A record's time is the stamp of the tick that completed its window minus (PAIRS-1)*8, modulo 2^32.
- R7: Records leave in detection order. While `out_valid` is 1 and `out_ready` is 0, the record on the output does not change.
- R8: The FIFO holds 16 records. A record produced while it is full is dropped, and `overflow` then stays 1 until reset.
- R9: After reset `out_valid` and `overflow` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A tick of lane samples is offered |
| in_ready | output | 1 | Block can accept a tick |
| in_lanes | input | 48 | Lane L sample in bits [L*12 +: 12], unsigned |
| ts_set | input | 1 | Load the tick counter |
| ts_set_value | input | 32 | Value loaded into the tick counter |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address: coefficients 0..PAIRS-1, threshold at PAIRS |
| cfg_wdata | input | 16 | Signed register write data |
| out_valid | output | 1 | A record is available |
| out_ready | input | 1 | Sink takes the record |
| out_channel | output | 5 | Channel number of the record |
| out_height | output | 32 | Signed weighted pulse height |
| out_time | output | 32 | Timestamp of the record |
| overflow | output | 1 | Sticky: a record was dropped |

## Verification
The extractor is driven with several input patterns:
- Flat baselines, which must yield no records.
- Single steps on chosen channels across all four lanes, which check the lane/slot mapping and the weighted sum with mixed-sign coefficients.
- A step exactly equal to the threshold next to one a single code above it, which separates the strict comparison from a non-strict one.
- Two-stage staircases, which show that only the first crossing of a channel is reported.
- A step taken before configuration, which confirms that the reset threshold blocks hits.
- A timestamp load near the top of the range, which exercises the back-dating and its wrap.
- A step on all 32 channels at once with the output stalled, which overfills the FIFO and shows that the first 16 records survive and the overflow flag sticks.
- Random-looking output stalls, which test that a waiting record stays stable.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_EVAL = 2'd1,
    SEQ_MAC  = 2'd2
  } seq_state_t;

  function automatic int safe_log2(input int value);
    return (value > 1) ? $clog2(value) : 1;
  endfunction
endpackage

// File: rtl/mcs_history.sv
module mcs_history #(
  parameter int CH       = 32,
  parameter int WIN      = 8,
  parameter int SAMPLE_W = 12,
  parameter int CH_W     = 5
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [CH_W-1:0]                rd_ch,
  output logic [(WIN-1)*SAMPLE_W-1:0]    rd_past,
  input  logic                           wr_en,
  input  logic [CH_W-1:0]                wr_ch,
  input  logic [SAMPLE_W-1:0]            wr_sample
);
  localparam int KEEP = WIN - 1;

  // Element KEEP-1 is the most recent stored sample of the channel.
  logic [SAMPLE_W-1:0] store [CH][KEEP];

  always_comb begin
    for (int j = 0; j < KEEP; j++) begin
      rd_past[j*SAMPLE_W +: SAMPLE_W] = store[rd_ch][j];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < CH; c++) begin
        for (int j = 0; j < KEEP; j++) begin
          store[c][j] <= '0;
        end
      end
    end else if (wr_en) begin
      for (int j = 0; j < KEEP - 1; j++) begin
        store[wr_ch][j] <= store[wr_ch][j+1];
      end
      store[wr_ch][KEEP-1] <= wr_sample;
    end
  end
endmodule

// File: rtl/mcs_mac.sv
module mcs_mac #(
  parameter int PAIRS    = 4,
  parameter int SAMPLE_W = 12,
  parameter int COEF_W   = 16,
  parameter int ACC_W    = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            start,
  input  logic [2*PAIRS*SAMPLE_W-1:0]     window,
  input  logic [PAIRS*COEF_W-1:0]         coefs,
  output logic                            busy,
  output logic                            done,
  output logic signed [ACC_W-1:0]         result
);
  import mcs_pkg::*;

  localparam int DIFF_W = SAMPLE_W + 1;
  localparam int PROD_W = DIFF_W + COEF_W;
  localparam int K_W    = safe_log2(PAIRS);

  logic [2*PAIRS*SAMPLE_W-1:0] win_q;
  logic [K_W-1:0]              k_q;
  logic signed [ACC_W-1:0]     acc_q;
  logic [SAMPLE_W-1:0]         hi_s, lo_s;
  logic signed [DIFF_W-1:0]    pair_diff;
  logic signed [COEF_W-1:0]    coef_k;
  logic signed [PROD_W-1:0]    product;
  logic                        last_k;

  always_comb begin
    int ki;
    ki        = int'(k_q);
    hi_s      = win_q[(PAIRS + ki)*SAMPLE_W +: SAMPLE_W];
    lo_s      = win_q[(PAIRS - 1 - ki)*SAMPLE_W +: SAMPLE_W];
    pair_diff = {1'b0, hi_s} - {1'b0, lo_s};
    coef_k    = coefs[ki*COEF_W +: COEF_W];
    product   = pair_diff * coef_k;
    last_k    = (ki == PAIRS - 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      k_q   <= '0;
      acc_q <= '0;
      win_q <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy  <= 1'b1;
        k_q   <= '0;
        acc_q <= '0;
        win_q <= window;
      end else if (busy) begin
        acc_q <= acc_q + ACC_W'(product);
        if (last_k) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          k_q <= k_q + 1'b1;
        end
      end
    end
  end

  assign result = acc_q;
endmodule

// File: rtl/mcs_rec_fifo.sv
module mcs_rec_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 69
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         overflow
);
  import mcs_pkg::*;

  localparam int PW = safe_log2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [PW:0]   count;
  logic          pop, accept, full;

  assign full      = (count == (PW+1)'(DEPTH));
  assign out_valid = (count != '0);
  assign pop       = out_valid && pop_ready;
  assign accept    = push && (!full || pop);
  assign out_data  = mem[rptr];

  always_ff @(posedge clk) begin
    if (accept) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr     <= '0;
      rptr     <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (accept) wptr <= (int'(wptr) == DEPTH - 1) ? '0 : wptr + 1'b1;
      if (pop)    rptr <= (int'(rptr) == DEPTH - 1) ? '0 : rptr + 1'b1;
      case ({accept, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (push && !accept) overflow <= 1'b1;
    end
  end

  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    count <= (PW+1)'(DEPTH));

  assert_overflow_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  assert_hold_output_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !pop_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/mcs_pulse_extractor.sv
module mcs_pulse_extractor #(
  parameter int LANES      = 4,
  parameter int SLOTS      = 8,
  parameter int SAMPLE_W   = 12,
  parameter int COEF_W     = 16,
  parameter int PAIRS      = 4,
  parameter int TS_W       = 32,
  parameter int FIFO_DEPTH = 16,
  parameter int CFG_ADDR_W = 4,
  localparam int CH        = LANES * SLOTS,
  localparam int CH_W      = mcs_pkg::safe_log2(CH),
  localparam int ACC_W     = SAMPLE_W + 1 + COEF_W + mcs_pkg::safe_log2(PAIRS) + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [LANES*SAMPLE_W-1:0] in_lanes,
  input  logic                      ts_set,
  input  logic [TS_W-1:0]           ts_set_value,
  input  logic                      cfg_we,
  input  logic [CFG_ADDR_W-1:0]     cfg_addr,
  input  logic [COEF_W-1:0]         cfg_wdata,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [CH_W-1:0]           out_channel,
  output logic [ACC_W-1:0]          out_height,
  output logic [TS_W-1:0]           out_time,
  output logic                      overflow
);
  import mcs_pkg::*;

  localparam int WIN    = 2 * PAIRS;
  localparam int SLOT_W = safe_log2(SLOTS);
  localparam int LANE_W = safe_log2(LANES);
  localparam int DIFF_W = SAMPLE_W + 1;
  localparam int CMP_W  = ((DIFF_W > COEF_W) ? DIFF_W : COEF_W) + 1;
  localparam int REC_W  = CH_W + ACC_W + TS_W;
  localparam logic [TS_W-1:0] BACKDATE = TS_W'((PAIRS - 1) * SLOTS);

  // Configuration registers
  logic signed [COEF_W-1:0] coef [PAIRS];
  logic signed [COEF_W-1:0] thresh;
  logic [PAIRS*COEF_W-1:0]  coef_flat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < PAIRS; k++) coef[k] <= '0;
      thresh <= {1'b0, {(COEF_W-1){1'b1}}};
    end else if (cfg_we) begin
      if (int'(cfg_addr) < PAIRS)       coef[cfg_addr] <= cfg_wdata;
      else if (int'(cfg_addr) == PAIRS) thresh <= cfg_wdata;
    end
  end

  for (genvar gk = 0; gk < PAIRS; gk++) begin : g_coef_flat
    assign coef_flat[gk*COEF_W +: COEF_W] = coef[gk];
  end

  // Tick sequencing and time base
  seq_state_t          state;
  logic [SLOT_W-1:0]   slot_q, cur_slot;
  logic [LANE_W-1:0]   lane_idx;
  logic [TS_W-1:0]     ts_q, cur_ts;
  logic [SAMPLE_W-1:0] lane_buf [LANES];
  logic                take_tick;
  logic                last_lane;

  assign in_ready  = (state == SEQ_IDLE);
  assign take_tick = in_valid && in_ready;
  assign last_lane = (int'(lane_idx) == LANES - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q <= '0;
      ts_q   <= '0;
    end else begin
      if (take_tick) slot_q <= (int'(slot_q) == SLOTS - 1) ? '0 : slot_q + 1'b1;
      if (ts_set)         ts_q <= ts_set_value;
      else if (take_tick) ts_q <= ts_q + 1'b1;
    end
  end

  // Window assembly and hit decision for the lane under evaluation
  logic [CH_W-1:0]              cur_ch;
  logic [SAMPLE_W-1:0]          newest;
  logic [(WIN-1)*SAMPLE_W-1:0]  past;
  logic [WIN*SAMPLE_W-1:0]      window;
  logic [SAMPLE_W-1:0]          edge_s, before_s;
  logic signed [DIFF_W-1:0]     inner_diff;
  logic signed [CMP_W-1:0]      diff_x, thr_x;
  logic                         over_thr, hit;
  logic [CH-1:0]                armed;
  logic                         evaluating;

  assign evaluating = (state == SEQ_EVAL);
  assign cur_ch     = CH_W'(int'(lane_idx) * SLOTS) + CH_W'(cur_slot);
  assign newest     = lane_buf[lane_idx];
  assign window     = {newest, past};
  assign edge_s     = window[PAIRS*SAMPLE_W +: SAMPLE_W];
  assign before_s   = window[(PAIRS-1)*SAMPLE_W +: SAMPLE_W];
  assign inner_diff = {1'b0, edge_s} - {1'b0, before_s};
  assign diff_x     = CMP_W'(inner_diff);
  assign thr_x      = CMP_W'(thresh);
  assign over_thr   = diff_x > thr_x;
  assign hit        = evaluating && over_thr && armed[cur_ch];

  mcs_history #(
    .CH(CH), .WIN(WIN), .SAMPLE_W(SAMPLE_W), .CH_W(CH_W)
  ) u_history (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_ch     (cur_ch),
    .rd_past   (past),
    .wr_en     (evaluating),
    .wr_ch     (cur_ch),
    .wr_sample (newest)
  );

  logic                    mac_busy, mac_done;
  logic signed [ACC_W-1:0] mac_result;

  mcs_mac #(
    .PAIRS(PAIRS), .SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W), .ACC_W(ACC_W)
  ) u_mac (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (hit),
    .window (window),
    .coefs  (coef_flat),
    .busy   (mac_busy),
    .done   (mac_done),
    .result (mac_result)
  );

  logic [CH_W-1:0] rec_ch;
  logic [TS_W-1:0] rec_time;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= SEQ_IDLE;
      lane_idx <= '0;
      cur_slot <= '0;
      cur_ts   <= '0;
      armed    <= '1;
      rec_ch   <= '0;
      rec_time <= '0;
      for (int l = 0; l < LANES; l++) lane_buf[l] <= '0;
    end else begin
      case (state)
        SEQ_IDLE: begin
          if (take_tick) begin
            for (int l = 0; l < LANES; l++) lane_buf[l] <= in_lanes[l*SAMPLE_W +: SAMPLE_W];
            cur_slot <= slot_q;
            cur_ts   <= ts_q;
            lane_idx <= '0;
            state    <= SEQ_EVAL;
          end
        end
        SEQ_EVAL: begin
          armed[cur_ch] <= !over_thr;
          rec_ch        <= cur_ch;
          rec_time      <= cur_ts - BACKDATE;
          if (hit) begin
            state <= SEQ_MAC;
          end else if (last_lane) begin
            state <= SEQ_IDLE;
          end else begin
            lane_idx <= lane_idx + 1'b1;
          end
        end
        SEQ_MAC: begin
          if (mac_done) begin
            if (last_lane) begin
              state <= SEQ_IDLE;
            end else begin
              lane_idx <= lane_idx + 1'b1;
              state    <= SEQ_EVAL;
            end
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  logic [REC_W-1:0] rec_in, rec_out;
  assign rec_in = {rec_ch, mac_result, rec_time};

  mcs_rec_fifo #(
    .DEPTH(FIFO_DEPTH), .W(REC_W)
  ) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (mac_done),
    .push_data (rec_in),
    .pop_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (rec_out),
    .overflow  (overflow)
  );

  assign out_channel = rec_out[REC_W-1 -: CH_W];
  assign out_height  = rec_out[TS_W +: ACC_W];
  assign out_time    = rec_out[TS_W-1:0];

  assert_slot_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    int'(slot_q) < SLOTS);

  assert_busy_blocks_input_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mac_busy |-> !in_ready);

  assert_done_in_mac_state_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mac_done |-> (state == SEQ_MAC));

  assert_start_when_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> !mac_busy);
endmodule

// File: tb/mcs_pulse_extractor_bench.sv
module mcs_pulse_extractor_bench;
  localparam int LANES = 4;
  localparam int SLOTS = 8;
  localparam int CH    = 32;
  localparam int PAIRS = 4;
  localparam int WIN   = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [47:0] in_lanes = '0;
  logic        ts_set = 1'b0;
  logic [31:0] ts_set_value = '0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [4:0]  out_channel;
  logic [31:0] out_height;
  logic [31:0] out_time;
  logic        overflow;

  always #4 clk = ~clk;

  mcs_pulse_extractor u_mcs_pulse_extractor (
    .clk, .rst_n, .in_valid, .in_ready, .in_lanes, .ts_set, .ts_set_value,
    .cfg_we, .cfg_addr, .cfg_wdata, .out_valid, .out_ready, .out_channel,
    .out_height, .out_time, .overflow
  );

  typedef struct { int ch; int h; logic [31:0] t; } rec_t;
  rec_t q[$];

  int errors = 0;
  int checks = 0;
  int lvl   [CH];
  int hist  [CH][WIN];
  bit armed [CH];
  int coef  [PAIRS];
  int thr = 32767;
  int slot_m = 0;
  logic [31:0] ts_m = '0;
  bit burst = 1'b0;
  bit stall = 1'b0;
  bit first_tick = 1'b1;
  int cyc = 0;
  bit done_flag = 1'b0;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input int addr, input int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'(addr); cfg_wdata = 16'(data);
    @(negedge clk);
    cfg_we = 1'b0;
    if (addr < PAIRS) coef[addr] = int'($signed(16'(data)));
    else if (addr == PAIRS) thr = int'($signed(16'(data)));
  endtask

  task automatic ts_load(input logic [31:0] v);
    @(negedge clk);
    ts_set = 1'b1; ts_set_value = v;
    @(negedge clk);
    ts_set = 1'b0;
    ts_m = v;
  endtask

  // Driver: offer one tick, model its effect and queue expected records
  task automatic tick();
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    for (int l = 0; l < LANES; l++) in_lanes[l*12 +: 12] = 12'(lvl[l*SLOTS + slot_m]);
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    if (first_tick) begin
      chk("R2 in_ready low after accept", in_ready, 0);
      first_tick = 1'b0;
    end
    for (int l = 0; l < LANES; l++) begin
      int c, d;
      bit over;
      c = l*SLOTS + slot_m;
      for (int i = 0; i < WIN-1; i++) hist[c][i] = hist[c][i+1];
      hist[c][WIN-1] = lvl[c];
      d = hist[c][PAIRS] - hist[c][PAIRS-1];
      over = d > thr;
      if (over && armed[c]) begin
        rec_t r;
        r.ch = c;
        r.h = 0;
        for (int k = 0; k < PAIRS; k++) r.h += coef[k] * (hist[c][PAIRS+k] - hist[c][PAIRS-1-k]);
        r.t = ts_m - 32'((PAIRS-1)*SLOTS);
        if (!burst || q.size() < 16) q.push_back(r);
      end
      armed[c] = !over;
    end
    slot_m = (slot_m + 1) % SLOTS;
    ts_m = ts_m + 1;
  endtask

  task automatic advance(input int samples);
    for (int i = 0; i < samples*SLOTS; i++) tick();
  endtask

  task automatic drain(input string tag);
    int n = 0;
    while ((q.size() != 0 || !in_ready || out_valid) && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk({tag, " pending expected records"}, q.size(), 0);
    chk({tag, " no extra record"}, out_valid, 0);
  endtask

  // Monitor: pops and compares records at the output
  logic        prev_wait = 1'b0;
  logic [4:0]  prev_ch;
  logic [31:0] prev_h, prev_t;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      out_ready = burst ? 1'b0 : (stall ? ((cyc % 3) != 0) : 1'b1);
      if (prev_wait) begin
        chk("R7 held channel", out_channel, prev_ch);
        chk("R7 held height", out_height, prev_h);
        chk("R7 held time", out_time, prev_t);
      end
      if (out_valid && out_ready) begin
        if (q.size() == 0) begin
          chk("R3 unexpected record channel", out_channel, -1);
        end else begin
          rec_t r;
          r = q.pop_front();
          chk("R1 record channel", out_channel, r.ch);
          chk("R4 record height", $signed(out_height), r.h);
          chk("R6 record time", out_time, r.t);
        end
      end
      prev_wait = out_valid && !out_ready;
      prev_ch = out_channel; prev_h = out_height; prev_t = out_time;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < CH; c++) begin
      lvl[c] = 0; armed[c] = 1'b1;
      for (int i = 0; i < WIN; i++) hist[c][i] = 0;
    end
    for (int k = 0; k < PAIRS; k++) coef[k] = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 in_ready after reset", in_ready, 1);
    chk("R9 out_valid after reset", out_valid, 0);
    chk("R9 overflow after reset", overflow, 0);

    // R5: reset threshold blocks a large step
    advance(2);
    lvl[0] = 900;
    advance(5);
    drain("R5 reset threshold");

    // Configure, plus an ignored write
    cfg_write(0, 3);
    cfg_write(1, -2);
    cfg_write(2, 5);
    cfg_write(3, 1);
    cfg_write(PAIRS, 100);
    cfg_write(9, 16'h0001);

    // Single steps on channels in different lanes and slots (R1, R4)
    stall = 1'b1;
    lvl[5] = 600;
    lvl[18] = 250;
    advance(6);
    drain("R4 single steps");

    // Strict threshold: exactly 100 is not a hit, 101 is (R3)
    lvl[26] = 100;
    advance(5);
    drain("R3 equal threshold");
    lvl[26] = 201;
    advance(5);
    drain("R3 above threshold");

    // Staircase: two consecutive crossings report once (R3)
    lvl[13] = 300;
    advance(1);
    lvl[13] = 600;
    advance(6);
    drain("R3 staircase");

    // Falling step gives no record; rising again does
    lvl[5] = 0;
    advance(5);
    lvl[31] = 777;
    advance(5);
    drain("R3 falling and rising");

    // Timestamp load and wrap (R6)
    stall = 1'b0;
    ts_load(32'hFFFF_FFF0);
    lvl[9] = 1200;
    advance(5);
    drain("R6 loaded stamp");

    // Overfill the FIFO with the output stalled (R8)
    burst = 1'b1;
    for (int c = 0; c < CH; c++) lvl[c] = lvl[c] + 400;
    advance(5);
    repeat (20) @(negedge clk);
    chk("R8 overflow flag set", overflow, 1);
    chk("R8 fifo holds records", out_valid, 1);
    chk("R8 model kept 16", q.size(), 16);
    burst = 1'b0;
    drain("R8 drain after overflow");
    chk("R8 overflow sticky", overflow, 1);

    done_flag = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule